// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block turns one accepted exception cause into the full architectural state change a processor core needs to enter the handler. On an accept strobe it reads the current machine state word, program counter, a small cause qualifier, the handler-address prefix, the relocated-handler mode and a power-save flag. From these it computes, in a single registered step, four things: which save/restore register pair is written, the values for that pair, the new machine state word and the handler address. Handler addresses come from a parameterised per-cause table.

The same block also performs return-from-interrupt. The core supplies the saved address and saved state word, and the block produces the restored program counter and state word. A machine check taken while machine checks are disabled puts the block into a sticky checkstop, and it then ignores all further requests until reset. Causes outside its scope raise an unsupported-cause error and leave the core state untouched. These are translation-buffer reload, assist, debug and performance-monitor causes.

Cause codes (4 bits): 0 system reset, 1 machine check, 2 external, 3 decrementer, 4 program, 5 system call, 6 data storage, 7 hypervisor decrementer, 8 hypervisor emulation assist, 13 facility unavailable. Every other code is out of scope. State-word bit positions (bit 0 is the least significant): RI 1, DR 4, IR 5, FE1 8, FE0 11, ME 12, FP 13, POW 18, HV 60, SF 63.

Top module: `exc_entry_seq`

## Requirements
- R1: Reset behaviour. While rst_n is low at a clock edge, all outputs clear to zero, including the checkstop flag. Results appear one clock after the edge that samples take_i or ret_i. The pulse outputs save_we_o, upd_o and the three error flags last exactly one cycle.
- R2: Saved status and saved address. For an accepted entry, save_msr_o is the current state word with bits 30:27 and 21:16 forced to zero, and save_pc_o is the current pc_i.
- R3: New state word base. The new state word keeps only the current ME and HV bits. Every other bit is zero unless a later rule sets it.
- R4: Machine check. With ME=1, the entry clears ME in the new state word and never applies the relocated-handler offset. With ME=0, halt_o is set with no commit, and it stays set. While halted, entries and returns produce no upd_o.
- R5: Program sub-cause. err_i selects a bit that is ORed into the saved status: 0 floating-point enabled 0x100000, 1 illegal 0x80000, 2 privileged 0x40000, 3 trap 0x20000.
- R6: A floating-point program cause is dropped when FP is 0, or when FE0 and FE1 are both 0. A dropped cause gives no upd_o, no save_we_o and no error.
- R7: System call. The saved address is pc_i+4. With err_i=1 the new state word also has HV set, and the normal pair is still used.
- R8: Hypervisor-class causes (7, 8) set hyp_sel_o to select the hypervisor save pair. They set HV in the new state word and copy the current RI bit into it.
- R9: Wake from power save (pwr_save_i=1). The saved status gets bit 16 set. A non-machine-check cause is redirected to the reset vector with a wake code in bits 21:18: reset 4, external 8, decrementer 6. Any other cause except machine check is unsupported.
- R10: The handler address is the table entry of the cause ORed with prefix_i. Entry c holds (c+1)*0x100 unless its bit in UNDEF_MASK is set, in which case it holds all ones. An all-ones entry raises err_undef_o instead of committing. The default mask marks code 13.
- R11: Relocated handlers. ail_i=2 ORs 0x18000 into the handler address and ail_i=3 ORs 0xC000000000004000; both also set IR and DR in the new state word. The offset applies only when the current IR and DR are both 1 and the entry does not raise HV from 0 to 1.
- R12: ail_i=1 raises err_ail_o alongside a normal commit and applies no offset.
- R13: An out-of-scope cause raises err_unsup_o with no upd_o and no save_we_o.
- R14: Return (ret_i, with take_i low) gives upd_o without save_we_o. The new state word is ret_msr_i with POW cleared. The new address is ret_pc_i with bits 1:0 cleared, truncated to 32 bits when SF of ret_msr_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | Accept strobe for an exception entry |
| code_i | input | 4 | Cause code |
| msr_i | input | 64 | Current machine state word |
| pc_i | input | 64 | Current program counter |
| err_i | input | 2 | Cause qualifier (program sub-cause, call level) |
| prefix_i | input | 64 | Handler address prefix |
| ail_i | input | 2 | Relocated-handler mode |
| pwr_save_i | input | 1 | Core is waking from power save |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ret_pc_i | input | 64 | Saved address to return to |
| ret_msr_i | input | 64 | Saved state word to restore |
| save_we_o | output | 1 | Write the save/restore pair |
| hyp_sel_o | output | 1 | Pair select: 1 hypervisor, 0 normal |
| save_pc_o | output | 64 | Value for the address half of the pair |
| save_msr_o | output | 64 | Value for the status half of the pair |
| upd_o | output | 1 | New state word and address are valid |
| new_msr_o | output | 64 | New machine state word |
| new_pc_o | output | 64 | New program counter |
| halt_o | output | 1 | Sticky checkstop |
| err_unsup_o | output | 1 | Unsupported cause |
| err_undef_o | output | 1 | Cause has no defined vector |
| err_ail_o | output | 1 | Invalid relocated-handler mode |

## Verification
The hardest path to reach is the interaction of the relocated-handler offset with the hypervisor transition. The offset must be suppressed only when HV rises, yet kept when HV was already set. Reaching it needs a state word with IR, DR and HV set or cleared on purpose, combined with hypervisor-class and ordinary causes. The vector table pairs the same cause and mode with both HV settings and with IR cleared. The sticky checkstop is reached late in the run by a machine check with ME cleared. The test then checks that following entries and returns are ignored, and that only reset clears the condition.

// File: rtl/exc_pkg.sv
// Shared constants for the exception entry sequencer.
// Assumes a 64-bit state word; bit 0 is the least significant.
package exc_pkg;
    localparam int RI_B  = 1;
    localparam int DR_B  = 4;
    localparam int IR_B  = 5;
    localparam int FE1_B = 8;
    localparam int FE0_B = 11;
    localparam int ME_B  = 12;
    localparam int FP_B  = 13;
    localparam int DOZE_B = 16;
    localparam int WAKE_LSB = 18;
    localparam int POW_B = 18;
    localparam int HV_B  = 60;
    localparam int SF_B  = 63;

    typedef enum logic [3:0] {
        C_RESET  = 4'd0,
        C_MCHK   = 4'd1,
        C_EXT    = 4'd2,
        C_DEC    = 4'd3,
        C_PROG   = 4'd4,
        C_SCALL  = 4'd5,
        C_DSTOR  = 4'd6,
        C_HDEC   = 4'd7,
        C_HEMU   = 4'd8,
        C_FUNAV  = 4'd13
    } cause_e;
endpackage

// File: rtl/exc_entry_calc.sv
// Per-cause rules: saved status, saved address, base of the new state word,
// pair select, drop/checkstop/unsupported flags. Purely combinational.
// Assumes XLEN is 64 so that all bit positions of exc_pkg exist.
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter bit SAVE_UNMASKED = 1'b0
) (
    input  logic [3:0]      code,
    input  logic [XLEN-1:0] msr,
    input  logic [XLEN-1:0] pc,
    input  logic [1:0]      err,
    input  logic            pwr_save,
    output logic [3:0]      eff_code,
    output logic [XLEN-1:0] save_pc,
    output logic [XLEN-1:0] save_msr,
    output logic [XLEN-1:0] base_msr,
    output logic            hyp,
    output logic            drop,
    output logic            chkstop,
    output logic            unsup,
    output logic            no_reloc
);
    localparam logic [XLEN-1:0] CLR_MASK = XLEN'(64'h0000_0000_783F_0000);

    logic [3:0] wake;

    // Apply wake redirect, then the rules of the effective cause.
    always_comb begin
        eff_code = code;
        save_msr = SAVE_UNMASKED ? msr : (msr & ~CLR_MASK);
        save_pc  = pc;
        base_msr = '0;
        base_msr[ME_B] = msr[ME_B];
        base_msr[HV_B] = msr[HV_B];
        hyp = 1'b0; drop = 1'b0; chkstop = 1'b0; unsup = 1'b0; no_reloc = 1'b0;
        wake = 4'd0;
        if (pwr_save) begin
            save_msr[DOZE_B] = 1'b1;
            if (code != C_MCHK) begin
                case (code)
                    C_RESET: wake = 4'h4;
                    C_EXT:   wake = 4'h8;
                    C_DEC:   wake = 4'h6;
                    default: unsup = 1'b1;
                endcase
                save_msr[WAKE_LSB +: 4] = save_msr[WAKE_LSB +: 4] | wake;
                eff_code = C_RESET;
            end
        end
        case (eff_code)
            C_RESET: no_reloc = 1'b1;
            C_MCHK: begin
                chkstop = ~msr[ME_B];
                base_msr[ME_B] = 1'b0;
                no_reloc = 1'b1;
            end
            C_EXT, C_DEC, C_DSTOR, C_FUNAV: ;
            C_PROG: begin
                case (err)
                    2'd0: begin
                        if ((!msr[FE0_B] && !msr[FE1_B]) || !msr[FP_B]) drop = 1'b1;
                        save_msr[20] = 1'b1;
                    end
                    2'd1: save_msr[19] = 1'b1;
                    2'd2: save_msr[18] = 1'b1;
                    default: save_msr[17] = 1'b1;
                endcase
            end
            C_SCALL: begin
                save_pc = pc + XLEN'(4);
                if (err == 2'd1) base_msr[HV_B] = 1'b1;
            end
            C_HDEC, C_HEMU: begin
                hyp = 1'b1;
                base_msr[HV_B] = 1'b1;
                base_msr[RI_B] = msr[RI_B];
            end
            default: unsup = 1'b1;
        endcase
    end
endmodule

// File: rtl/exc_vector_sel.sv
// Handler address: per-cause vector table ORed with prefix, plus the
// relocated-handler offset when its conditions hold. Table loads at reset.
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NCODE = 16,
    parameter int VEC_STEP = 256,
    parameter logic [NCODE-1:0] UNDEF_MASK = 16'h2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NCODE)-1:0] code,
    input  logic [XLEN-1:0]          prefix,
    input  logic [1:0]               ail,
    input  logic                     allow,
    input  logic [XLEN-1:0]          cur_msr,
    input  logic [XLEN-1:0]          msr_in,
    output logic [XLEN-1:0]          handler,
    output logic [XLEN-1:0]          msr_out,
    output logic                     undef,
    output logic                     ail_bad
);
    localparam logic [XLEN-1:0] OFS_LOW  = XLEN'(32'h0001_8000);
    localparam logic [XLEN-1:0] OFS_HIGH = {2'b11, {(XLEN-2){1'b0}}} | XLEN'(32'h4000);

    logic [XLEN-1:0] tbl [NCODE];
    logic [XLEN-1:0] entry;
    logic            apply;

    for (genvar i = 0; i < NCODE; i++) begin : g_tbl
        // Load entry i with its computed vector or the undefined marker.
        always_ff @(posedge clk) begin
            if (!rst_n) tbl[i] <= UNDEF_MASK[i] ? '1 : XLEN'((i + 1) * VEC_STEP);
        end
    end

    // Look up, test for undefined, and apply the relocation offset.
    always_comb begin
        entry   = tbl[code];
        undef   = &entry;
        ail_bad = (ail == 2'd1);
        apply   = allow && ail[1] && cur_msr[IR_B] && cur_msr[DR_B]
                  && !(msr_in[HV_B] && !cur_msr[HV_B]);
        handler = entry | prefix;
        msr_out = msr_in;
        if (apply) begin
            msr_out[IR_B] = 1'b1;
            msr_out[DR_B] = 1'b1;
            handler = handler | (ail[0] ? OFS_HIGH : OFS_LOW);
        end
    end
endmodule

// File: rtl/exc_return_calc.sv
// Return-from-interrupt: clear POW, align address, truncate in 32-bit mode.
module exc_return_calc
    import exc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ret_pc,
    input  logic [XLEN-1:0] ret_msr,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] msr_out
);
    // Form the restored state word and address.
    always_comb begin
        msr_out = ret_msr;
        msr_out[POW_B] = 1'b0;
        pc_out = ret_pc & ~XLEN'(3);
        if (!ret_msr[SF_B]) pc_out[XLEN-1:32] = '0;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry and return sequencer top. Commits every update in the
// cycle after take_i or ret_i; take_i wins if both are high. Sticky
// checkstop blocks all later requests until reset. Sync active-low reset.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NCODE = 16,
    parameter int VEC_STEP = 256,
    parameter logic [NCODE-1:0] UNDEF_MASK = 16'h2000,
    parameter bit SAVE_UNMASKED = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [3:0]      code_i,
    input  logic [63:0]     msr_i,
    input  logic [63:0]     pc_i,
    input  logic [1:0]      err_i,
    input  logic [63:0]     prefix_i,
    input  logic [1:0]      ail_i,
    input  logic            pwr_save_i,
    input  logic            ret_i,
    input  logic [63:0]     ret_pc_i,
    input  logic [63:0]     ret_msr_i,
    output logic            save_we_o,
    output logic            hyp_sel_o,
    output logic [63:0]     save_pc_o,
    output logic [63:0]     save_msr_o,
    output logic            upd_o,
    output logic [63:0]     new_msr_o,
    output logic [63:0]     new_pc_o,
    output logic            halt_o,
    output logic            err_unsup_o,
    output logic            err_undef_o,
    output logic            err_ail_o
);
    logic [3:0]      eff_code;
    logic [XLEN-1:0] c_spc, c_smsr, c_base, v_pc, v_msr, r_pc, r_msr;
    logic            c_hyp, c_drop, c_chk, c_unsup, c_noreloc, v_undef, v_ailbad;

    exc_entry_calc #(.XLEN(XLEN), .SAVE_UNMASKED(SAVE_UNMASKED)) u_calc (
        .code(code_i), .msr(msr_i), .pc(pc_i), .err(err_i), .pwr_save(pwr_save_i),
        .eff_code(eff_code), .save_pc(c_spc), .save_msr(c_smsr), .base_msr(c_base),
        .hyp(c_hyp), .drop(c_drop), .chkstop(c_chk), .unsup(c_unsup),
        .no_reloc(c_noreloc)
    );

    exc_vector_sel #(.XLEN(XLEN), .NCODE(NCODE), .VEC_STEP(VEC_STEP),
                     .UNDEF_MASK(UNDEF_MASK)) u_vec (
        .clk(clk), .rst_n(rst_n), .code(eff_code[$clog2(NCODE)-1:0]),
        .prefix(prefix_i), .ail(ail_i), .allow(!c_noreloc), .cur_msr(msr_i),
        .msr_in(c_base), .handler(v_pc), .msr_out(v_msr), .undef(v_undef),
        .ail_bad(v_ailbad)
    );

    exc_return_calc #(.XLEN(XLEN)) u_ret (
        .ret_pc(ret_pc_i), .ret_msr(ret_msr_i), .pc_out(r_pc), .msr_out(r_msr)
    );

    // Commit entry, return, errors or checkstop on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_we_o <= 1'b0; hyp_sel_o <= 1'b0; save_pc_o <= '0; save_msr_o <= '0;
            upd_o <= 1'b0; new_msr_o <= '0; new_pc_o <= '0; halt_o <= 1'b0;
            err_unsup_o <= 1'b0; err_undef_o <= 1'b0; err_ail_o <= 1'b0;
        end else begin
            save_we_o <= 1'b0; upd_o <= 1'b0;
            err_unsup_o <= 1'b0; err_undef_o <= 1'b0; err_ail_o <= 1'b0;
            if (!halt_o) begin
                if (take_i) begin
                    if (c_unsup)       err_unsup_o <= 1'b1;
                    else if (c_chk)    halt_o <= 1'b1;
                    else if (v_undef)  err_undef_o <= 1'b1;
                    else if (!c_drop) begin
                        save_we_o  <= 1'b1;
                        upd_o      <= 1'b1;
                        hyp_sel_o  <= c_hyp;
                        save_pc_o  <= c_spc;
                        save_msr_o <= c_smsr;
                        new_msr_o  <= v_msr;
                        new_pc_o   <= v_pc;
                        err_ail_o  <= v_ailbad;
                    end
                end else if (ret_i) begin
                    upd_o     <= 1'b1;
                    new_msr_o <= r_msr;
                    new_pc_o  <= r_pc;
                end
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
// Checker for exc_entry_seq, attached by bind. Observes ports only.
module exc_entry_seq_chk
    import exc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        save_we_o,
    input logic        hyp_sel_o,
    input logic        upd_o,
    input logic [63:0] new_msr_o,
    input logic [63:0] new_pc_o,
    input logic        halt_o,
    input logic        err_unsup_o,
    input logic        err_undef_o
);
    localparam logic [63:0] ALLOWED = (64'h1 << ME_B) | (64'h1 << HV_B) |
        (64'h1 << RI_B) | (64'h1 << IR_B) | (64'h1 << DR_B);

    // R4
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);
    // R4
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !upd_o);
    // R3
    entry_msr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_we_o |-> ((new_msr_o & ~ALLOWED) == 64'h0));
    // R8
    hyp_sets_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_we_o && hyp_sel_o) |-> new_msr_o[HV_B]);
    // R13
    err_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unsup_o || err_undef_o) |-> (!upd_o && !save_we_o));
    // R14
    ret_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && !save_we_o) |-> (new_pc_o[1:0] == 2'b00 && !new_msr_o[POW_B]));
    // R1
    save_implies_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_we_o |-> upd_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .save_we_o(save_we_o), .hyp_sel_o(hyp_sel_o),
    .upd_o(upd_o), .new_msr_o(new_msr_o), .new_pc_o(new_pc_o), .halt_o(halt_o),
    .err_unsup_o(err_unsup_o), .err_undef_o(err_undef_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    typedef struct packed {
        logic [3:0]  code;
        logic [63:0] msr;
        logic [63:0] pc;
        logic [63:0] prefix;
        logic [1:0]  err;
        logic [1:0]  ail;
        logic        pws;
        logic        we;
        logic        hyp;
        logic [63:0] spc;
        logic [63:0] smsr;
        logic [63:0] nmsr;
        logic [63:0] npc;
        logic [2:0]  errs;   // {unsup, undef, ail}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        // R2 external, mask clears 30:27 and 21:16
        '{4'd2, 64'h1000_0000_7FFF_1032, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h1000_0000_07C0_1032, 64'h1000_0000_0000_1000, 64'h300, 3'b000, 8'd2},
        // R11 mode 2, HV already set
        '{4'd2, 64'h1000_0000_7FFF_1032, 64'h4000, 64'h0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h1000_0000_07C0_1032, 64'h1000_0000_0000_1030, 64'h18300, 3'b000, 8'd11},
        // R11 mode 3
        '{4'd3, 64'h1030, 64'h4000, 64'h0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h1030, 64'h1030, 64'hC000_0000_0000_4400, 3'b000, 8'd11},
        // R8 hyp decrementer, HV rises so no offset
        '{4'd7, 64'h1032, 64'h4000, 64'h0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1,
          64'h4000, 64'h1032, 64'h1000_0000_0000_1002, 64'h800, 3'b000, 8'd8},
        // R5 illegal, R10 prefix
        '{4'd4, 64'h1000, 64'h2000, 64'hFFF0_0000, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h2000, 64'h81000, 64'h1000, 64'hFFF0_0500, 3'b000, 8'd5},
        // R5 trap
        '{4'd4, 64'h0, 64'h4000, 64'h0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h20000, 64'h0, 64'h500, 3'b000, 8'd5},
        // R5 privileged
        '{4'd4, 64'h0, 64'h4000, 64'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h40000, 64'h0, 64'h500, 3'b000, 8'd5},
        // R5 floating-point enabled
        '{4'd4, 64'h2900, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h102900, 64'h0, 64'h500, 3'b000, 8'd5},
        // R6 FP bit clear
        '{4'd4, 64'h0900, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, 64'h0, 3'b000, 8'd6},
        // R6 FE0 and FE1 clear
        '{4'd4, 64'h2000, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, 64'h0, 3'b000, 8'd6},
        // R7 call level 1
        '{4'd5, 64'h1000, 64'h3000, 64'h0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h3004, 64'h1000, 64'h1000_0000_0000_1000, 64'h600, 3'b000, 8'd7},
        // R7 call level 0
        '{4'd5, 64'h1000, 64'h3000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h3004, 64'h1000, 64'h1000, 64'h600, 3'b000, 8'd7},
        // R4 machine check enabled, offset suppressed
        '{4'd1, 64'h1030, 64'h4000, 64'h0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h1030, 64'h0, 64'h200, 3'b000, 8'd4},
        // R9 wake on external
        '{4'd2, 64'h1000, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0,
          64'h4000, 64'h211000, 64'h1000, 64'h100, 3'b000, 8'd9},
        // R9 wake on decrementer
        '{4'd3, 64'h0, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0,
          64'h4000, 64'h190000, 64'h0, 64'h100, 3'b000, 8'd9},
        // R9 wake on reset
        '{4'd0, 64'h0, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0,
          64'h4000, 64'h110000, 64'h0, 64'h100, 3'b000, 8'd9},
        // R9 wake on machine check keeps its own vector
        '{4'd1, 64'h1000, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0,
          64'h4000, 64'h11000, 64'h0, 64'h200, 3'b000, 8'd9},
        // R9 wake on program is unsupported
        '{4'd4, 64'h0, 64'h4000, 64'h0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, 64'h0, 3'b100, 8'd9},
        // R13 out-of-scope code
        '{4'd9, 64'h0, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, 64'h0, 3'b100, 8'd13},
        // R10 undefined vector
        '{4'd13, 64'h0, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, 64'h0, 3'b010, 8'd10},
        // R12 invalid mode, still commits
        '{4'd6, 64'h30, 64'h4000, 64'h0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h30, 64'h0, 64'h700, 3'b001, 8'd12},
        // R8 emulation assist copies RI
        '{4'd8, 64'h1000_0000_0000_0002, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1,
          64'h4000, 64'h1000_0000_0000_0002, 64'h1000_0000_0000_0002, 64'h900, 3'b000, 8'd8},
        // R3 all-ones state word keeps only ME and HV
        '{4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4000, 64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'hFFFF_FFFF_87C0_FFFF, 64'h1000_0000_0000_1000, 64'h700, 3'b000, 8'd3},
        // R11 IR only: no offset
        '{4'd3, 64'h1020, 64'h4000, 64'h0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0,
          64'h4000, 64'h1020, 64'h1000, 64'h400, 3'b000, 8'd11}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic take_i = 1'b0, ret_i = 1'b0, pwr_save_i = 1'b0;
    logic [3:0] code_i = '0;
    logic [1:0] err_i = '0, ail_i = '0;
    logic [63:0] msr_i = '0, pc_i = '0, prefix_i = '0, ret_pc_i = '0, ret_msr_i = '0;
    logic save_we_o, hyp_sel_o, upd_o, halt_o, err_unsup_o, err_undef_o, err_ail_o;
    logic [63:0] save_pc_o, save_msr_o, new_msr_o, new_pc_o;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i), .msr_i(msr_i),
        .pc_i(pc_i), .err_i(err_i), .prefix_i(prefix_i), .ail_i(ail_i),
        .pwr_save_i(pwr_save_i), .ret_i(ret_i), .ret_pc_i(ret_pc_i),
        .ret_msr_i(ret_msr_i), .save_we_o(save_we_o), .hyp_sel_o(hyp_sel_o),
        .save_pc_o(save_pc_o), .save_msr_o(save_msr_o), .upd_o(upd_o),
        .new_msr_o(new_msr_o), .new_pc_o(new_pc_o), .halt_o(halt_o),
        .err_unsup_o(err_unsup_o), .err_undef_o(err_undef_o), .err_ail_o(err_ail_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One-cycle strobe driven at a falling edge, result sampled one falling edge later.
    task automatic pulse(input logic is_take, input logic is_ret);
        @(negedge clk);
        take_i = is_take; ret_i = is_ret;
        @(negedge clk);
        take_i = 1'b0; ret_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 upd", {63'd0, upd_o}, 64'd0);
        check("R1 halt", {63'd0, halt_o}, 64'd0);
        check("R1 new_pc", new_pc_o, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            code_i = TBL[i].code; msr_i = TBL[i].msr; pc_i = TBL[i].pc;
            prefix_i = TBL[i].prefix; err_i = TBL[i].err; ail_i = TBL[i].ail;
            pwr_save_i = TBL[i].pws;
            pulse(1'b1, 1'b0);
            check($sformatf("R%0d v%0d save_we", TBL[i].req, i), {63'd0, save_we_o}, {63'd0, TBL[i].we});
            check($sformatf("R%0d v%0d upd", TBL[i].req, i), {63'd0, upd_o}, {63'd0, TBL[i].we});
            check($sformatf("R%0d v%0d errs", TBL[i].req, i),
                  {61'd0, err_unsup_o, err_undef_o, err_ail_o}, {61'd0, TBL[i].errs});
            if (TBL[i].we) begin
                check($sformatf("R%0d v%0d hyp", TBL[i].req, i), {63'd0, hyp_sel_o}, {63'd0, TBL[i].hyp});
                check($sformatf("R%0d v%0d save_pc", TBL[i].req, i), save_pc_o, TBL[i].spc);
                check($sformatf("R%0d v%0d save_msr", TBL[i].req, i), save_msr_o, TBL[i].smsr);
                check($sformatf("R%0d v%0d new_msr", TBL[i].req, i), new_msr_o, TBL[i].nmsr);
                check($sformatf("R%0d v%0d new_pc", TBL[i].req, i), new_pc_o, TBL[i].npc);
            end
            @(negedge clk);
            // R1 pulses last one cycle
            check($sformatf("R1 v%0d pulse end", i), {63'd0, upd_o | save_we_o}, 64'd0);
        end
        pwr_save_i = 1'b0; ail_i = 2'd0; prefix_i = '0;

        // R14 return in 64-bit mode
        ret_pc_i = 64'h1234_5678_9ABC_DEF7; ret_msr_i = 64'h8000_0000_0004_1000;
        pulse(1'b0, 1'b1);
        check("R14 ret upd", {62'd0, upd_o, save_we_o}, 64'd2);
        check("R14 ret msr", new_msr_o, 64'h8000_0000_0000_1000);
        check("R14 ret pc", new_pc_o, 64'h1234_5678_9ABC_DEF4);
        // R14 return in 32-bit mode
        ret_msr_i = 64'h0000_0000_0004_1000;
        pulse(1'b0, 1'b1);
        check("R14 ret32 msr", new_msr_o, 64'h1000);
        check("R14 ret32 pc", new_pc_o, 64'h9ABC_DEF4);

        // R4 machine check with ME clear enters checkstop
        code_i = 4'd1; msr_i = 64'h0; pc_i = 64'h4000;
        pulse(1'b1, 1'b0);
        check("R4 halt set", {63'd0, halt_o}, 64'd1);
        check("R4 no commit", {63'd0, upd_o}, 64'd0);
        code_i = 4'd2; msr_i = 64'h1000;
        pulse(1'b1, 1'b0);
        check("R4 entry ignored", {63'd0, upd_o}, 64'd0);
        pulse(1'b0, 1'b1);
        check("R4 return ignored", {63'd0, upd_o}, 64'd0);
        check("R4 halt sticky", {63'd0, halt_o}, 64'd1);

        // R1 reset clears checkstop
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 halt cleared", {63'd0, halt_o}, 64'd0);
        check("R1 outputs cleared", save_msr_o | new_msr_o | save_pc_o, 64'd0);
        rst_n = 1'b1;
        code_i = 4'd2; msr_i = 64'h1000; pc_i = 64'h4000;
        pulse(1'b1, 1'b0);
        check("R1 entry after reset", new_pc_o, 64'h300);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule